// File: doc/BRIEF.md
# Chained 48-Channel PWM LED Driver Core

This core drives 48 LED channels, each set by a 9-bit duty value. Colour data arrives one whole 9-bit word at a time on a parallel data input. Each accepted rising edge of a slow shift-clock input pushes a new word into a 48-word chain. The word in the last stage is always presented on a parallel cascade output. Several cores can therefore be wired in series, with each cascade output feeding the data input of the next core.

A rising edge on the strobe input copies the whole chain into a bank of pending duty registers. The pending bank moves into the active duty bank only when the PWM period wraps, so a period that is already running is never cut short or glitched. A free-running 9-bit counter advances once per rising edge of a separate PWM reference input. Each channel is on while the counter is below that channel's active duty.

The shift clock and the strobe are acted on only while both chip selects are asserted. One chip select is active-low and the other is active-high. The output enable does not change the PWM state. It only sets a per-channel drive-enable mask that stands in for tri-state pads. Every slow input is synchronised into one system clock and edge-detected there.

Top module: `led_pwm_driver`

## Requirements
- R1: While `arst_n` is low, and right after it is released, `dout`, `led_on` and every internal duty register and counter read zero.
- R2: Each accepted shift-clock rising edge loads `din` into channel 0 and moves every channel up by one. `dout` shows channel 47, so the first of 48 accepted words is the one on `dout`.
- R3: A shift-clock or strobe edge is acted on only when `sel_n` is 0 and `sel` is 1. Otherwise the chain, the pending bank and the outputs stay as they were.
- R4: An accepted strobe edge copies all 48 chain words into the pending bank. It does not change `led_on` within the running period.
- R5: The PWM counter starts at 0 and steps by one on each rising edge of `pwm_ref`. After 511 it returns to 0. It holds between edges.
- R6: `led_on[i]` is 1 exactly when the counter is below channel i's active duty. Duty 0 never lights the channel, and duty 511 lights it for 511 of the 512 counts.
- R7: The active duty bank takes the pending bank's contents only on the `pwm_ref` edge that moves the counter from 511 to 0.
- R8: `drive_en` is all ones while `oe_n` is 0 and all zeros while `oe_n` is 1. `oe_n` has no effect on `led_on`.
- R9: An input held high for many cycles counts as one edge. One shift or one counter step happens per rising edge, however long the level is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| din | input | 9 | Parallel colour word into the chain |
| sclk_in | input | 1 | Shift clock, rising edge active |
| strobe_in | input | 1 | Strobe, rising edge copies chain to pending bank |
| sel_n | input | 1 | Active-low chip select |
| sel | input | 1 | Active-high chip select |
| oe_n | input | 1 | Active-low output enable |
| pwm_ref | input | 1 | PWM reference clock, rising edge advances counter |
| dout | output | 9 | Cascade output, word held in channel 47 |
| led_on | output | 48 | Per-channel PWM level |
| drive_en | output | 48 | Per-channel pad drive enable |

## Verification
The embedded assertions check the following on every cycle:
- Synchronised edges last one cycle.
- The head of the chain takes the data word on a shift.
- The chain, cascade word and pending bank hold when chip selection fails or no edge arrives.
- The counter steps, holds and wraps correctly.
- The active bank changes only at the wrap.
- A zero duty never lights its channel.

Only the bench scenarios can show:
- The first word sent comes out of the cascade port after exactly 48 shifts.
- A strobe issued in the middle of a period stays invisible until the wrap.
- Duties of 1, 510 and 511 light their channels for the right counts.
- A long-held input level produces a single action.

// File: rtl/led_drv_pkg.sv
package led_drv_pkg;
  // Qualified one-cycle events after synchronisation and chip selection.
  typedef struct packed {
    logic shift;
    logic latch;
    logic tick;
  } led_evt_t;
endpackage

// File: rtl/led_edge_sync.sv
module led_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              last_q, last_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], async_in};
    last_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= last_d;
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;

  // R9: a held level yields one pulse only
  p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/led_shift_chain.sv
module led_shift_chain #(
  parameter int CH = 48,
  parameter int DW = 9
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   shift_en,
  input  logic [DW-1:0]          din,
  output logic [CH-1:0][DW-1:0]  words_o,
  output logic [DW-1:0]          dout
);
  logic [CH-1:0][DW-1:0] words_q, words_d;

  always_comb begin
    words_d = words_q;
    if (shift_en) begin
      words_d[0] = din;
      for (int i = 1; i < CH; i++) words_d[i] = words_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) words_q <= '0;
    else        words_q <= words_d;
  end

  assign words_o = words_q;
  assign dout    = words_q[CH-1];

  p_head_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> words_q[0] == $past(din));
  p_tail_move_r2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> dout == $past(words_q[CH-2]));
  p_chain_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(words_q));
endmodule

// File: rtl/led_pwm_engine.sv
module led_pwm_engine #(
  parameter int CH = 48,
  parameter int DW = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic                  latch,
  input  logic [CH-1:0][DW-1:0] load_words,
  output logic [CH-1:0]         led_on
);
  localparam logic [DW-1:0] CNT_MAX = '1;

  logic [CH-1:0][DW-1:0] pend_q, pend_d;
  logic [CH-1:0][DW-1:0] act_q, act_d;
  logic [DW-1:0]         cnt_q, cnt_d;
  logic                  period_end;

  assign period_end = tick && (cnt_q == CNT_MAX);

  always_comb begin
    pend_d = pend_q;
    act_d  = act_q;
    cnt_d  = cnt_q;
    if (latch)      pend_d = load_words;
    if (tick)       cnt_d  = cnt_q + 1'b1;
    if (period_end) act_d  = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
      cnt_q  <= '0;
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
      cnt_q  <= cnt_d;
    end
  end

  for (genvar g = 0; g < CH; g++) begin : g_cmp
    assign led_on[g] = (cnt_q < act_q[g]);
    p_zero_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q[g] == '0) |-> !led_on[g]);
  end

  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> cnt_q == '0);
  p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1);
  p_cnt_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));
  p_act_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> act_q == $past(pend_q));
  p_act_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !period_end |=> $stable(act_q));
  p_pend_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !latch |=> $stable(pend_q));
endmodule

// File: rtl/led_pwm_driver.sv
module led_pwm_driver
  import led_drv_pkg::*;
#(
  parameter int CH = 48,
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic [DW-1:0] din,
  input  logic          sclk_in,
  input  logic          strobe_in,
  input  logic          sel_n,
  input  logic          sel,
  input  logic          oe_n,
  input  logic          pwm_ref,
  output logic [DW-1:0] dout,
  output logic [CH-1:0] led_on,
  output logic [CH-1:0] drive_en
);
  logic rst_meta_q, rst_n;
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rst_meta_q <= 1'b0;
      rst_n      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n      <= rst_meta_q;
    end
  end

  logic sclk_rise, strobe_rise, ref_rise, sel_ok;
  led_evt_t evt;
  logic [CH-1:0][DW-1:0] chain_words;

  led_edge_sync #(.STAGES(2)) u_sclk (.clk(clk), .rst_n(rst_n), .async_in(sclk_in),   .rise_o(sclk_rise));
  led_edge_sync #(.STAGES(2)) u_stb  (.clk(clk), .rst_n(rst_n), .async_in(strobe_in), .rise_o(strobe_rise));
  led_edge_sync #(.STAGES(2)) u_ref  (.clk(clk), .rst_n(rst_n), .async_in(pwm_ref),   .rise_o(ref_rise));

  assign sel_ok    = ~sel_n & sel;
  assign evt.shift = sclk_rise & sel_ok;
  assign evt.latch = strobe_rise & sel_ok;
  assign evt.tick  = ref_rise;

  led_shift_chain #(.CH(CH), .DW(DW)) u_chain (
    .clk(clk), .rst_n(rst_n), .shift_en(evt.shift), .din(din),
    .words_o(chain_words), .dout(dout));

  led_pwm_engine #(.CH(CH), .DW(DW)) u_pwm (
    .clk(clk), .rst_n(rst_n), .tick(evt.tick), .latch(evt.latch),
    .load_words(chain_words), .led_on(led_on));

  assign drive_en = {CH{~oe_n}};

  p_sel_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_rise && !sel_ok) |=> $stable(dout));
  p_reset_zero_r1: assert property (@(posedge clk)
    !rst_n |-> (dout == '0 && led_on == '0));
endmodule

// File: tb/sim_led_pwm_driver.sv
module sim_led_pwm_driver;
  localparam int CH = 48;
  localparam int DW = 9;

  logic clk = 1'b0;
  logic arst_n, sclk_in, strobe_in, sel_n, sel, oe_n, pwm_ref;
  logic [DW-1:0] din, dout;
  logic [CH-1:0] led_on, drive_en;

  always #2 clk = ~clk;

  led_pwm_driver #(.CH(CH), .DW(DW)) u0 (
    .clk(clk), .arst_n(arst_n), .din(din), .sclk_in(sclk_in), .strobe_in(strobe_in),
    .sel_n(sel_n), .sel(sel), .oe_n(oe_n), .pwm_ref(pwm_ref),
    .dout(dout), .led_on(led_on), .drive_en(drive_en));

  int n_vec = 0;
  int n_bad = 0;
  logic [DW-1:0] m_chain [CH];
  logic [DW-1:0] m_pend  [CH];
  logic [DW-1:0] m_act   [CH];
  int m_cnt = 0;

  function automatic logic [CH-1:0] exp_on();
    logic [CH-1:0] v;
    for (int i = 0; i < CH; i++) v[i] = (m_cnt < int'(m_act[i]));
    return v;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_shift(logic [DW-1:0] w, bit ok_n, bit ok_h, int hold);
    @(negedge clk);
    din = w; sel_n = ok_n; sel = ok_h; sclk_in = 1'b1;
    repeat (hold) @(negedge clk);
    if (!ok_n && ok_h) begin
      for (int i = CH-1; i > 0; i--) m_chain[i] = m_chain[i-1];
      m_chain[0] = w;
      chk("R2 cascade word", 64'(dout), 64'(m_chain[CH-1]));
    end else begin
      chk("R3 shift ignored", 64'(dout), 64'(m_chain[CH-1]));
    end
    sclk_in = 1'b0;
    repeat (3) @(negedge clk);
    sel_n = 1'b0; sel = 1'b1;
  endtask

  task automatic do_strobe(bit ok_n, bit ok_h);
    @(negedge clk);
    sel_n = ok_n; sel = ok_h; strobe_in = 1'b1;
    repeat (4) @(negedge clk);
    if (!ok_n && ok_h) for (int i = 0; i < CH; i++) m_pend[i] = m_chain[i];
    chk("R4 no visible change on strobe", 64'(led_on), 64'(exp_on()));
    strobe_in = 1'b0;
    repeat (3) @(negedge clk);
    sel_n = 1'b0; sel = 1'b1;
  endtask

  task automatic do_tick();
    @(negedge clk);
    pwm_ref = 1'b1;
    repeat (4) @(negedge clk);
    if (m_cnt == 511) begin
      m_cnt = 0;
      for (int i = 0; i < CH; i++) m_act[i] = m_pend[i];
    end else m_cnt++;
    chk("R5 R6 R7 levels", 64'(led_on), 64'(exp_on()));
    pwm_ref = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1ed5));
    for (int i = 0; i < CH; i++) begin m_chain[i] = '0; m_pend[i] = '0; m_act[i] = '0; end
    arst_n = 1'b0; din = '0; sclk_in = 0; strobe_in = 0;
    sel_n = 0; sel = 1; oe_n = 0; pwm_ref = 0;
    repeat (5) @(negedge clk);
    chk("R1 dout in reset", 64'(dout), 64'd0);
    chk("R1 led_on in reset", 64'(led_on), 64'd0);
    arst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 dout after reset", 64'(dout), 64'd0);

    oe_n = 1'b1; @(negedge clk);
    chk("R8 drive off", 64'(drive_en), 64'd0);
    chk("R8 led_on unaffected", 64'(led_on), 64'(exp_on()));
    oe_n = 1'b0; @(negedge clk);
    chk("R8 drive on", 64'(drive_en), {16'd0, {CH{1'b1}}});

    // Directed load: first word 511 ends up in channel 47
    for (int k = 0; k < CH; k++) begin
      logic [DW-1:0] w;
      case (k)
        0: w = 9'd511; 1: w = 9'd0; 2: w = 9'd1; 3: w = 9'd510;
        default: w = DW'($urandom % 512);
      endcase
      do_shift(w, 1'b0, 1'b1, 4);
    end
    chk("R2 first word at cascade", 64'(dout), 64'd511);

    // Selection gating
    do_shift(9'h0AA, 1'b1, 1'b1, 4);
    do_shift(9'h155, 1'b0, 1'b0, 4);
    do_shift(9'h0F0, 1'b1, 1'b0, 4);
    chk("R3 chain kept", 64'(dout), 64'd511);

    // R9: long hold gives one shift only
    do_shift(9'h123, 1'b0, 1'b1, 20);

    do_strobe(1'b1, 1'b1);  // rejected, R3
    do_strobe(1'b0, 1'b1);  // accepted
    // Period 0 keeps zero duties; then new values show; mid-period strobe
    for (int t = 0; t < 700; t++) begin
      do_tick();
      if (t == 600) begin
        for (int k = 0; k < 6; k++) do_shift(DW'($urandom % 512), 1'b0, 1'b1, 4);
        do_strobe(1'b0, 1'b1);
      end
    end

    // Random mix
    for (int it = 0; it < 1600; it++) begin
      int r;
      r = int'($urandom % 12);
      if (r < 8) do_tick();
      else if (r < 10) do_shift(DW'($urandom % 512), bit'($urandom % 4 == 0), bit'($urandom % 4 != 0), 4);
      else if (r < 11) do_strobe(bit'($urandom % 3 == 0), 1'b1);
      else begin
        oe_n = ~oe_n; @(negedge clk);
        chk("R8 mask", 64'(drive_en), oe_n ? 64'd0 : {16'd0, {CH{1'b1}}});
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule